// File: doc/BRIEF.md
# Context-Switch Microcode Sequencer

This block is a small microprogrammed engine that saves or restores a unit's register context. Before a switch, a host fills its instruction memory through a simple write port and states how many words the program holds. A start pulse then runs the program from address zero. Every cycle in the running state, the engine fetches one 32-bit word and executes it. A program can:

- move a block of consecutive registers between the register file and a context memory;
- load a stream-length register;
- branch or wait on one bit of a flat 128-entry flag space;
- write a flag;
- issue a few control strobes, one of which ends the program.

A single direction flag sets which way every block move goes. With the flag at one, a move saves register-file words into the context memory. With the flag at zero, a move loads context-memory words back into the register file. A context-position pointer counts the context words moved since start, and it is the context-memory address of every move. Idle status, auto save and auto load requests come in as live flag inputs. User save and user load requests set sticky flags, and the program clears those flags itself.

The controller has four states. SQ_IDLE waits for start. SQ_RUN fetches and executes one word per cycle. SQ_MOVE moves one word per cycle for a block transfer. SQ_FAULT halts after a bad instruction address.

The transitions are as follows:

- **launch**: SQ_IDLE or SQ_FAULT to SQ_RUN, on start.
- **block**: SQ_RUN to SQ_MOVE, on a transfer with a count other than zero.
- **resume**: SQ_MOVE to SQ_RUN, after the last word.
- **finish**: SQ_RUN to SQ_IDLE, on end-of-program.
- **trap**: SQ_RUN to SQ_FAULT, on a fetch or branch address that is not below the program length.

Top module: `ctxsw_sequencer`

## Requirements
- R1: After reset, run_o, done_o, fault_o, swap_o, current_o, ctxptr_o, rf_we and cm_we are low, stream_len is zero and the direction flag is zero.
- R2: start in SQ_IDLE or SQ_FAULT sets the instruction pointer and the context-position pointer to zero and clears fault_o; the engine then executes from word 0.
- R3: Bits 23:20 select the class: 1 block transfer, 2 stream-length load, 4 branch, 5 wait, 6 special command, 7 flag write. Any other class value is a no-op that only advances the pointer.
- R4: In a block transfer, bits 19:14 give the count N and bits 13:0 give the first register index R. With the direction flag at 1, N cycles each write cm_wdata = register R+i to cm_addr = position, for i from 0 to N-1. A count of 0 moves nothing.
- R5: With the direction flag at 0, a block transfer instead writes rf_wdata = context word at the current position into register R+i.
- R6: The context-position pointer advances by one per moved word and carries over from one transfer to the next within a run.
- R7: A stream-length load puts bits 19:0 on stream_len.
- R8: A branch reads its target from bits 15:8 and its flag index from bits 6:0. With bit 7 at 0 it is taken when the flag is 1, and with bit 7 at 1 it is taken when the flag is 0. A branch that is not taken falls through.
- R9: A wait holds the instruction pointer until the flag named by bits 6:0 equals bit 7.
- R10: A flag write stores bit 7 into the flag named by bits 6:0. Only indices 0 (direction), 5 (user save) and 6 (user load) are writable. Writes to 96, 104, 100, 101 and any other index have no effect.
- R11: Flag reads: index 96 follows hw_busy, 100 follows auto_save_req, 101 follows auto_load_req, and 104 is always 1. A pulse on user_save_req sets flag 5, and a pulse on user_load_req sets flag 6. Every unimplemented index reads 0.
- R12: Special commands decode bits 19:0 as follows: 0x00007 pulses swap_o, 0x00009 pulses current_o and 0x0000a pulses ctxptr_o, each for one cycle. 0x0000e returns to SQ_IDLE with a one-cycle done_o. Any other code is a no-op.
- R13: A fetch address or a taken-branch target that is not below prog_len enters SQ_FAULT. In that state fault_o goes high, run_o goes low, and no further writes, strobes or done occur until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch pulse |
| prog_we | input | 1 | Instruction-memory write enable |
| prog_addr | input | IP_W | Instruction-memory write address |
| prog_data | input | 32 | Instruction word to store |
| prog_len | input | IP_W+1 | Number of valid program words |
| hw_busy | input | 1 | Busy status (flag 96, 0 = idle) |
| auto_save_req | input | 1 | Automatic save pending (flag 100) |
| auto_load_req | input | 1 | Automatic load pending (flag 101) |
| user_save_req | input | 1 | Pulse that sets flag 5 |
| user_load_req | input | 1 | Pulse that sets flag 6 |
| rf_addr | output | REG_W | Register-file index |
| rf_we | output | 1 | Register-file write enable |
| rf_wdata | output | DATA_W | Register-file write data |
| rf_rdata | input | DATA_W | Register-file read data (combinational) |
| cm_addr | output | CTX_AW | Context-memory address |
| cm_we | output | 1 | Context-memory write enable |
| cm_wdata | output | DATA_W | Context-memory write data |
| cm_rdata | input | DATA_W | Context-memory read data (combinational) |
| stream_len | output | 20 | Stream-length register |
| run_o | output | 1 | High in SQ_RUN and SQ_MOVE |
| done_o | output | 1 | One-cycle end-of-program pulse |
| fault_o | output | 1 | High while halted in SQ_FAULT |
| swap_o | output | 1 | Next-to-swap strobe |
| current_o | output | 1 | Next-to-current strobe |
| ctxptr_o | output | 1 | Set-context-pointer strobe |

## Verification
The bench builds the sequencer with IP_W set to 5, which gives a 32-word instruction memory and a 6-bit program length. With that size, branch targets beyond the stored program can be encoded directly in the 8-bit target field. Short programs can also run their fetch pointer past prog_len, so both causes of fault are exercised. The register and context widths keep their default values. Every moved word then carries its full 14-bit register index or 16-bit position in its data, so both the direction and the address sequence can be seen at the ports.

// File: rtl/ctxsw_pkg.sv
package ctxsw_pkg;

    localparam int INSN_W  = 32;
    localparam int FLAG_W  = 7;
    localparam int SLEN_W  = 20;
    localparam int CNT_W   = 6;
    localparam int RIDX_W  = 14;

    // instruction classes, bits 23:20
    localparam logic [3:0] OPC_XFER = 4'h1;
    localparam logic [3:0] OPC_LSR  = 4'h2;
    localparam logic [3:0] OPC_BRA  = 4'h4;
    localparam logic [3:0] OPC_WAIT = 4'h5;
    localparam logic [3:0] OPC_SPEC = 4'h6;
    localparam logic [3:0] OPC_SETF = 4'h7;

    // flag indices (word*32+bit)
    localparam logic [FLAG_W-1:0] FLG_DIR   = 7'd0;
    localparam logic [FLAG_W-1:0] FLG_USAVE = 7'd5;
    localparam logic [FLAG_W-1:0] FLG_ULOAD = 7'd6;
    localparam logic [FLAG_W-1:0] FLG_BUSY  = 7'd96;
    localparam logic [FLAG_W-1:0] FLG_ASAVE = 7'd100;
    localparam logic [FLAG_W-1:0] FLG_ALOAD = 7'd101;
    localparam logic [FLAG_W-1:0] FLG_TRUE  = 7'd104;

    // special command codes, bits 19:0
    localparam logic [SLEN_W-1:0] SPC_SWAP = 20'h00007;
    localparam logic [SLEN_W-1:0] SPC_CUR  = 20'h00009;
    localparam logic [SLEN_W-1:0] SPC_PTR  = 20'h0000a;
    localparam logic [SLEN_W-1:0] SPC_END  = 20'h0000e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_RUN,
        SQ_MOVE,
        SQ_FAULT
    } sq_state_e;

    typedef struct packed {
        logic [3:0]        opc;
        logic [CNT_W-1:0]  cnt;
        logic [RIDX_W-1:0] reg_idx;
        logic [SLEN_W-1:0] imm;
        logic [7:0]        target;
        logic              polarity;
        logic [FLAG_W-1:0] flag;
    } insn_t;

    function automatic insn_t split_insn(input logic [INSN_W-1:0] w);
        insn_t f;
        f.opc      = w[23:20];
        f.cnt      = w[19:14];
        f.reg_idx  = w[13:0];
        f.imm      = w[19:0];
        f.target   = w[15:8];
        f.polarity = w[7];
        f.flag     = w[6:0];
        return f;
    endfunction

endpackage

// File: rtl/ctxsw_imem.sv
module ctxsw_imem #(
    parameter int AW = 8,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/ctxsw_flags.sv
module ctxsw_flags
    import ctxsw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [FLAG_W-1:0] wr_idx,
    input  logic              wr_val,
    input  logic              usave_req,
    input  logic              uload_req,
    input  logic              hw_busy,
    input  logic              auto_save,
    input  logic              auto_load,
    input  logic [FLAG_W-1:0] rd_idx,
    output logic              rd_val,
    output logic              dir_o
);
    logic dir_q;
    logic usave_q;
    logic uload_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q   <= 1'b0;
            usave_q <= 1'b0;
            uload_q <= 1'b0;
        end else begin
            if (wr_en && wr_idx == FLG_DIR) begin
                dir_q <= wr_val;
            end
            if (usave_req) begin
                usave_q <= 1'b1;
            end else if (wr_en && wr_idx == FLG_USAVE) begin
                usave_q <= wr_val;
            end
            if (uload_req) begin
                uload_q <= 1'b1;
            end else if (wr_en && wr_idx == FLG_ULOAD) begin
                uload_q <= wr_val;
            end
        end
    end

    always_comb begin
        case (rd_idx)
            FLG_DIR:   rd_val = dir_q;
            FLG_USAVE: rd_val = usave_q;
            FLG_ULOAD: rd_val = uload_q;
            FLG_BUSY:  rd_val = hw_busy;
            FLG_ASAVE: rd_val = auto_save;
            FLG_ALOAD: rd_val = auto_load;
            FLG_TRUE:  rd_val = 1'b1;
            default:   rd_val = 1'b0;
        endcase
    end

    assign dir_o = dir_q;

    // R10
    dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_idx == FLG_DIR) |=> $stable(dir_q));

    // R11
    ureq_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        usave_req |=> usave_q);

endmodule

// File: rtl/ctxsw_sequencer.sv
module ctxsw_sequencer
    import ctxsw_pkg::*;
#(
    parameter int IP_W   = 8,
    parameter int REG_W  = 14,
    parameter int CTX_AW = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              prog_we,
    input  logic [IP_W-1:0]   prog_addr,
    input  logic [INSN_W-1:0] prog_data,
    input  logic [IP_W:0]     prog_len,
    input  logic              hw_busy,
    input  logic              auto_save_req,
    input  logic              auto_load_req,
    input  logic              user_save_req,
    input  logic              user_load_req,
    output logic [REG_W-1:0]  rf_addr,
    output logic              rf_we,
    output logic [DATA_W-1:0] rf_wdata,
    input  logic [DATA_W-1:0] rf_rdata,
    output logic [CTX_AW-1:0] cm_addr,
    output logic              cm_we,
    output logic [DATA_W-1:0] cm_wdata,
    input  logic [DATA_W-1:0] cm_rdata,
    output logic [SLEN_W-1:0] stream_len,
    output logic              run_o,
    output logic              done_o,
    output logic              fault_o,
    output logic              swap_o,
    output logic              current_o,
    output logic              ctxptr_o
);
    localparam int CW = (IP_W + 1 > 8) ? IP_W + 1 : 8;

    sq_state_e         state_q, state_d;
    logic [IP_W-1:0]   ip_q, ip_d;
    logic [CTX_AW-1:0] pos_q, pos_d;
    logic [REG_W-1:0]  base_q, base_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [CNT_W-1:0]  idx_q, idx_d;
    logic [SLEN_W-1:0] slen_q, slen_d;
    logic              fault_q, fault_d;
    logic              done_q, done_d;
    logic              swap_q, swap_d;
    logic              cur_q, cur_d;
    logic              ptr_q, ptr_d;
    logic              fl_we;

    logic [INSN_W-1:0] word;
    insn_t             ins;
    logic              flag_v;
    logic              dir;
    logic              ip_ok;
    logic              tgt_ok;

    ctxsw_imem #(.AW(IP_W), .DW(INSN_W)) u_imem (
        .clk     (clk),
        .wr_en   (prog_we),
        .wr_addr (prog_addr),
        .wr_data (prog_data),
        .rd_addr (ip_q),
        .rd_data (word)
    );

    assign ins    = split_insn(word);
    assign ip_ok  = {1'b0, ip_q} < prog_len;
    assign tgt_ok = CW'(ins.target) < CW'(prog_len);

    ctxsw_flags u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (fl_we),
        .wr_idx    (ins.flag),
        .wr_val    (ins.polarity),
        .usave_req (user_save_req),
        .uload_req (user_load_req),
        .hw_busy   (hw_busy),
        .auto_save (auto_save_req),
        .auto_load (auto_load_req),
        .rd_idx    (ins.flag),
        .rd_val    (flag_v),
        .dir_o     (dir)
    );

    // next state and datapath updates
    always_comb begin
        state_d = state_q;
        ip_d    = ip_q;
        pos_d   = pos_q;
        base_d  = base_q;
        cnt_d   = cnt_q;
        idx_d   = idx_q;
        slen_d  = slen_q;
        fault_d = fault_q;
        done_d  = 1'b0;
        swap_d  = 1'b0;
        cur_d   = 1'b0;
        ptr_d   = 1'b0;
        fl_we   = 1'b0;
        unique case (state_q)
            SQ_IDLE, SQ_FAULT: begin
                if (start) begin
                    state_d = SQ_RUN;
                    ip_d    = '0;
                    pos_d   = '0;
                    fault_d = 1'b0;
                end
            end
            SQ_RUN: begin
                if (!ip_ok) begin
                    state_d = SQ_FAULT;
                    fault_d = 1'b1;
                end else begin
                    case (ins.opc)
                        OPC_XFER: begin
                            ip_d = ip_q + 1'b1;
                            if (ins.cnt != '0) begin
                                state_d = SQ_MOVE;
                                base_d  = REG_W'(ins.reg_idx);
                                cnt_d   = ins.cnt;
                                idx_d   = '0;
                            end
                        end
                        OPC_LSR: begin
                            slen_d = ins.imm;
                            ip_d   = ip_q + 1'b1;
                        end
                        OPC_BRA: begin
                            if (flag_v != ins.polarity) begin
                                if (tgt_ok) begin
                                    ip_d = IP_W'(ins.target);
                                end else begin
                                    state_d = SQ_FAULT;
                                    fault_d = 1'b1;
                                end
                            end else begin
                                ip_d = ip_q + 1'b1;
                            end
                        end
                        OPC_WAIT: begin
                            if (flag_v == ins.polarity) begin
                                ip_d = ip_q + 1'b1;
                            end
                        end
                        OPC_SETF: begin
                            fl_we = 1'b1;
                            ip_d  = ip_q + 1'b1;
                        end
                        OPC_SPEC: begin
                            ip_d = ip_q + 1'b1;
                            case (ins.imm)
                                SPC_SWAP: swap_d = 1'b1;
                                SPC_CUR:  cur_d  = 1'b1;
                                SPC_PTR:  ptr_d  = 1'b1;
                                SPC_END: begin
                                    state_d = SQ_IDLE;
                                    done_d  = 1'b1;
                                end
                                default: ;
                            endcase
                        end
                        default: ip_d = ip_q + 1'b1;
                    endcase
                end
            end
            SQ_MOVE: begin
                pos_d = pos_q + 1'b1;
                idx_d = idx_q + 1'b1;
                if (idx_q == cnt_q - 1'b1) begin
                    state_d = SQ_RUN;
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            ip_q    <= '0;
            pos_q   <= '0;
            base_q  <= '0;
            cnt_q   <= '0;
            idx_q   <= '0;
            slen_q  <= '0;
            fault_q <= 1'b0;
            done_q  <= 1'b0;
            swap_q  <= 1'b0;
            cur_q   <= 1'b0;
            ptr_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            ip_q    <= ip_d;
            pos_q   <= pos_d;
            base_q  <= base_d;
            cnt_q   <= cnt_d;
            idx_q   <= idx_d;
            slen_q  <= slen_d;
            fault_q <= fault_d;
            done_q  <= done_d;
            swap_q  <= swap_d;
            cur_q   <= cur_d;
            ptr_q   <= ptr_d;
        end
    end

    // outputs
    always_comb begin
        rf_addr    = base_q + REG_W'(idx_q);
        cm_addr    = pos_q;
        cm_we      = (state_q == SQ_MOVE) && dir;
        rf_we      = (state_q == SQ_MOVE) && !dir;
        cm_wdata   = rf_rdata;
        rf_wdata   = cm_rdata;
        stream_len = slen_q;
        run_o      = (state_q == SQ_RUN) || (state_q == SQ_MOVE);
        done_o     = done_q;
        fault_o    = fault_q;
        swap_o     = swap_q;
        current_o  = cur_q;
        ctxptr_o   = ptr_q;
    end

    // R12
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    // R12
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done_q, swap_q, cur_q, ptr_q}));

    // R6
    pos_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_MOVE) |=> (pos_q == $past(pos_q) + 1'b1));

    // R13
    fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_q |-> (!cm_we && !rf_we && !done_q && !run_o));

    // R2
    launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !run_o) |=> (run_o && ip_q == '0 && pos_q == '0 && !fault_q));

endmodule

// File: tb/test_ctxsw_sequencer.sv
module test_ctxsw_sequencer;
    localparam int IP_W = 5;
    localparam int EV_CM = 1, EV_RF = 2, EV_SWAP = 3, EV_CUR = 4, EV_PTR = 5, EV_DONE = 6;

    typedef struct {
        int          kind;
        logic [31:0] a;
        logic [31:0] d;
        string       tag;
    } ev_t;

    logic clk = 0, rst_n = 0, start = 0, prog_we = 0;
    logic [IP_W-1:0] prog_addr = '0;
    logic [31:0] prog_data = '0;
    logic [IP_W:0] prog_len = '0;
    logic hw_busy = 0, auto_save_req = 0, auto_load_req = 0, user_save_req = 0, user_load_req = 0;
    logic [13:0] rf_addr;
    logic rf_we, cm_we, run_o, done_o, fault_o, swap_o, current_o, ctxptr_o;
    logic [31:0] rf_wdata, rf_rdata, cm_wdata, cm_rdata;
    logic [15:0] cm_addr;
    logic [19:0] stream_len;

    int total = 0, bad = 0, cyc = 0;
    ev_t sb[$];
    logic [31:0] pbuf [32];

    function automatic logic [31:0] rfd(input logic [13:0] a);
        return {16'hA500, 2'b00, a};
    endfunction
    function automatic logic [31:0] cmd(input logic [15:0] a);
        return {16'hC300, a};
    endfunction

    assign rf_rdata = rfd(rf_addr);
    assign cm_rdata = cmd(cm_addr);

    ctxsw_sequencer #(.IP_W(IP_W)) i_ctxsw_sequencer (
        .clk(clk), .rst_n(rst_n), .start(start), .prog_we(prog_we), .prog_addr(prog_addr),
        .prog_data(prog_data), .prog_len(prog_len), .hw_busy(hw_busy),
        .auto_save_req(auto_save_req), .auto_load_req(auto_load_req),
        .user_save_req(user_save_req), .user_load_req(user_load_req),
        .rf_addr(rf_addr), .rf_we(rf_we), .rf_wdata(rf_wdata), .rf_rdata(rf_rdata),
        .cm_addr(cm_addr), .cm_we(cm_we), .cm_wdata(cm_wdata), .cm_rdata(cm_rdata),
        .stream_len(stream_len), .run_o(run_o), .done_o(done_o), .fault_o(fault_o),
        .swap_o(swap_o), .current_o(current_o), .ctxptr_o(ctxptr_o)
    );

    always #2 clk = ~clk;

    // instruction encoders
    function automatic logic [31:0] i_xfer(input int n, input int r);
        return 32'h0010_0000 | (32'(n) << 14) | 32'(r);
    endfunction
    function automatic logic [31:0] i_lsr(input logic [19:0] v);
        return 32'h0020_0000 | {12'h0, v};
    endfunction
    function automatic logic [31:0] i_bra(input int tgt, input logic ifclr, input int fl);
        return 32'h0040_0000 | (32'(tgt) << 8) | (32'(ifclr) << 7) | 32'(fl);
    endfunction
    function automatic logic [31:0] i_wait(input logic v, input int fl);
        return 32'h0050_0000 | (32'(v) << 7) | 32'(fl);
    endfunction
    function automatic logic [31:0] i_set(input logic v, input int fl);
        return 32'h0070_0000 | (32'(v) << 7) | 32'(fl);
    endfunction
    function automatic logic [31:0] i_spec(input logic [19:0] c);
        return 32'h0060_0000 | {12'h0, c};
    endfunction

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic push(input int k, input logic [31:0] a, input logic [31:0] d, input string tag);
        ev_t e;
        e.kind = k; e.a = a; e.d = d; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic observe(input int k, input logic [31:0] a, input logic [31:0] d);
        ev_t e;
        total++;
        if (sb.size() == 0) begin
            bad++;
            $display("FAIL unexpected event kind=%0d actual=%0h/%0h expected=none", k, a, d);
        end else begin
            e = sb.pop_front();
            if (e.kind != k || e.a != a || e.d != d) begin
                bad++;
                $display("FAIL %s actual=%0d/%0h/%0h expected=%0d/%0h/%0h",
                         e.tag, k, a, d, e.kind, e.a, e.d);
            end
        end
    endtask

    // monitor: compares each port event against the scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (cm_we)     observe(EV_CM, 32'(cm_addr), cm_wdata);
            if (rf_we)     observe(EV_RF, 32'(rf_addr), rf_wdata);
            if (swap_o)    observe(EV_SWAP, 0, 0);
            if (current_o) observe(EV_CUR, 0, 0);
            if (ctxptr_o)  observe(EV_PTR, 0, 0);
            if (done_o)    observe(EV_DONE, 0, 0);
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=finish", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic load_prog(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            prog_we = 1; prog_addr = IP_W'(i); prog_data = pbuf[i];
        end
        @(posedge clk); #1;
        prog_we = 0;
        prog_len = (IP_W+1)'(n);
    endtask

    task automatic launch();
        @(posedge clk); #1;
        start = 1;
        @(posedge clk); #1;
        start = 0;
    endtask

    task automatic wait_idle(input string tag);
        int n = 0;
        while (run_o && n < 2000) begin
            @(negedge clk);
            n++;
        end
        @(negedge clk);
        @(negedge clk);
        chk(!run_o, {tag, " run ends"}, 32'(run_o), 0);
        chk(sb.size() == 0, {tag, " all expected events seen"}, sb.size(), 0);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(!run_o && !done_o && !fault_o, "R1 status idle", {run_o, done_o, fault_o}, 0);
        chk(!swap_o && !current_o && !ctxptr_o, "R1 strobes low", {swap_o, current_o, ctxptr_o}, 0);
        chk(!rf_we && !cm_we, "R1 no writes", {rf_we, cm_we}, 0);
        chk(stream_len == 0, "R1 stream_len", stream_len, 0);

        // R4 R6 save direction
        pbuf[0] = i_set(1, 0);
        pbuf[1] = i_xfer(3, 'h10);
        pbuf[2] = i_spec(20'he);
        load_prog(3);
        for (int i = 0; i < 3; i++) push(EV_CM, i, rfd(14'(16 + i)), "R4 save word");
        push(EV_DONE, 0, 0, "R12 done after save");
        launch();
        wait_idle("R4");

        // R5 R6 R7 R3 R12 load direction, position restarts at start (R2)
        pbuf[0] = i_set(0, 0);
        pbuf[1] = i_lsr(20'h12345);
        pbuf[2] = i_xfer(2, 'h20);
        pbuf[3] = 32'h0030_0000;
        pbuf[4] = i_xfer(1, 'h30);
        pbuf[5] = i_xfer(0, 'h40);
        pbuf[6] = i_spec(20'h7);
        pbuf[7] = i_spec(20'h9);
        pbuf[8] = i_spec(20'ha);
        pbuf[9] = i_spec(20'h3);
        pbuf[10] = i_spec(20'he);
        load_prog(11);
        push(EV_RF, 'h20, cmd(0), "R5 R2 load word 0");
        push(EV_RF, 'h21, cmd(1), "R5 load word 1");
        push(EV_RF, 'h30, cmd(2), "R6 position carries over");
        push(EV_SWAP, 0, 0, "R12 swap strobe");
        push(EV_CUR, 0, 0, "R12 current strobe");
        push(EV_PTR, 0, 0, "R12 ctxptr strobe");
        push(EV_DONE, 0, 0, "R12 done after load");
        launch();
        wait_idle("R5");
        chk(stream_len == 20'h12345, "R7 stream_len", stream_len, 32'h12345);

        // R8 R11 branches on user flags
        @(posedge clk); #1 user_save_req = 1;
        @(posedge clk); #1 user_save_req = 0;
        pbuf[0] = i_bra(3, 0, 5);
        pbuf[1] = i_spec(20'h7);
        pbuf[2] = i_spec(20'he);
        pbuf[3] = i_set(0, 5);
        pbuf[4] = i_bra(1, 0, 5);
        pbuf[5] = i_bra(7, 1, 6);
        pbuf[6] = i_spec(20'h7);
        pbuf[7] = i_spec(20'h9);
        pbuf[8] = i_bra(2, 0, 104);
        load_prog(9);
        push(EV_CUR, 0, 0, "R8 branch path");
        push(EV_DONE, 0, 0, "R8 done");
        launch();
        wait_idle("R8");

        // R9 wait on busy status
        hw_busy = 1;
        pbuf[0] = i_wait(0, 96);
        pbuf[1] = i_spec(20'h7);
        pbuf[2] = i_spec(20'he);
        load_prog(3);
        launch();
        repeat (20) @(negedge clk);
        chk(run_o, "R9 still waiting", 32'(run_o), 1);
        push(EV_SWAP, 0, 0, "R9 released after idle");
        push(EV_DONE, 0, 0, "R9 done");
        @(posedge clk); #1 hw_busy = 0;
        wait_idle("R9");

        // R10 writes to hardware-owned and unimplemented flags ignored
        pbuf[0] = i_set(1, 96);
        pbuf[1] = i_set(0, 104);
        pbuf[2] = i_set(1, 50);
        pbuf[3] = i_bra(7, 0, 96);
        pbuf[4] = i_bra(7, 1, 104);
        pbuf[5] = i_bra(7, 0, 50);
        pbuf[6] = i_spec(20'he);
        pbuf[7] = i_spec(20'h7);
        pbuf[8] = i_spec(20'he);
        load_prog(9);
        push(EV_DONE, 0, 0, "R10 no branch taken");
        launch();
        wait_idle("R10");

        // R11 auto request flags
        pbuf[0] = i_bra(2, 0, 100);
        pbuf[1] = i_spec(20'he);
        pbuf[2] = i_spec(20'h9);
        pbuf[3] = i_spec(20'he);
        load_prog(4);
        auto_save_req = 1;
        push(EV_CUR, 0, 0, "R11 auto save seen");
        push(EV_DONE, 0, 0, "R11 done");
        launch();
        wait_idle("R11a");
        auto_save_req = 0;
        push(EV_DONE, 0, 0, "R11 auto save clear");
        launch();
        wait_idle("R11b");
        pbuf[0] = i_bra(2, 0, 101);
        load_prog(4);
        auto_load_req = 1;
        push(EV_CUR, 0, 0, "R11 auto load seen");
        push(EV_DONE, 0, 0, "R11 done");
        launch();
        wait_idle("R11c");
        auto_load_req = 0;

        // R13 branch target out of range
        pbuf[0] = i_bra(20, 0, 104);
        pbuf[1] = i_spec(20'he);
        load_prog(2);
        launch();
        wait_idle("R13a");
        chk(fault_o, "R13 fault on target", 32'(fault_o), 1);
        // R13 fetch overrun
        pbuf[0] = i_spec(20'h9);
        load_prog(1);
        push(EV_CUR, 0, 0, "R13 before overrun");
        launch();
        wait_idle("R13b");
        chk(fault_o, "R13 fault on fetch", 32'(fault_o), 1);
        // R2 start clears fault
        pbuf[0] = i_spec(20'he);
        load_prog(1);
        push(EV_DONE, 0, 0, "R2 restart after fault");
        launch();
        wait_idle("R2");
        chk(!fault_o, "R2 fault cleared", 32'(fault_o), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule